// File: doc/BRIEF.md
# Push-Pull Gate Drive with Cycle-by-Cycle Current Limit

This block produces two complementary gate-drive signals for a push-pull or half-bridge power stage. A free-running period counter splits every switching period into two halves. Drive A conducts at the start of the first half and drive B at the start of the second. The on-time of each drive is programmable. A programmable dead interval always separates one drive turning off from the other turning on. A typical setting is a 100 kHz period with each drive on for about a third of it.

A signed current sample is compared every clock against a symmetric window of plus and minus a programmable limit. When the sample leaves the window, both drives are cut off for what remains of the current period and a limit flag is raised. The limit is re-examined only when a new period begins. If the sample is back inside the window at that moment, switching resumes in that period. If it is not, the whole period is skipped and the test is repeated at the next period start. The limit therefore never adds switching edges in the middle of a cycle. Period, on-time, dead time and limit are sampled into working registers only at a period boundary.

Top module: `pushpull_limit_drv`

## Requirements
- R1: The two drives conduct alternately: drive A only in the first half of a period, drive B only in the second half, and the two are never high in the same cycle.
- R2: With P = max(period_cfg, 2) and H = floor(P/2), a period lasts P clocks. Drive A rises at the period's first clock and drive B rises H clocks later. Each pulse lasts the effective on-time. For an odd P, the gap from the fall of B to the next rise of A is P - H - on.
- R3: The effective on-time is min(on_cfg, H - dead_cfg), or zero when dead_cfg >= H. In that zero case neither drive is ever high, and every gap between one drive falling and the other rising is at least dead_cfg clocks.
- R4: Writes to period, on-time, dead time or limit take effect only from the next period start. A pulse already in progress keeps its old width.
- R5: The sample and the limit are signed two's complement. The sample is outside the window only when it is greater than +limit or less than -limit. A sample equal to +limit or to -limit is inside the window.
- R6: At the clock edge where an outside sample is seen, both drives go low and limit_flag goes high. They stay that way for the rest of that period, even if the sample returns inside the window.
- R7: limit_flag can fall only at a period start, and only if the sample is inside the window at that start. If the sample is outside at the start, neither drive is high during that whole period.
- R8: While reset is high or en is low, both drives and limit_flag are low at the next clock and the period counter returns to zero. After en is seen high at a clock edge, drive A rises at the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds both drives off |
| period_cfg | input | CW | Switching period in clocks |
| on_cfg | input | CW | Requested on-time per drive in clocks |
| dead_cfg | input | CW | Minimum dead interval in clocks |
| limit_cfg | input | SW | Window half-width, signed |
| i_sample | input | SW | Current sample, signed |
| drv_a | output | 1 | Gate drive, first half of the period |
| drv_b | output | 1 | Gate drive, second half of the period |
| limit_flag | output | 1 | High while the current limit is holding the drives off |

## Verification
The two functions that can fall in the same cycle are the period-start re-examination of the window and the trip by an outside sample. The sample that a period start looks at decides both whether an earlier limit is released and whether a new one begins. The bench provokes this by holding the sample outside the window across a period boundary, then bringing it back mid-period. It checks that the whole boundary period stays dark, that nothing restarts at the release, and that limit_flag drops exactly at the clock where drive A next rises. The exact clock count from release to restart is the measure.

// File: rtl/pp_pkg.sv
package pp_pkg;

  // Segment of the switching period the counter currently sits in.
  typedef enum logic [1:0] {
    SEG_A_ON  = 2'd0,
    SEG_A_OFF = 2'd1,
    SEG_B_ON  = 2'd2,
    SEG_B_OFF = 2'd3
  } seg_e;

endpackage

// File: rtl/pp_timebase.sv
module pp_timebase #(
  parameter int CW = 16,
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] on_i,
  input  logic [CW-1:0] dead_i,
  input  logic [SW-1:0] limit_i,
  output logic          run_o,
  output logic          start_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] half_o,
  output logic [CW-1:0] on_o,
  output logic [CW-1:0] dead_o,
  output logic [SW-1:0] limit_o
);

  localparam logic [CW-1:0] MIN_PER = CW'(2);

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] per_r, half_r, on_r, dead_r;
  logic [SW-1:0] lim_r;

  logic [CW-1:0] per_c, half_c, room_c, on_c;
  logic          wrap, load;

  // Clamp the request so that on-time plus dead time fits in half a period.
  always_comb begin
    per_c  = (period_i < MIN_PER) ? MIN_PER : period_i;
    half_c = per_c >> 1;
    room_c = (dead_i >= half_c) ? '0 : (half_c - dead_i);
    on_c   = (on_i > room_c) ? room_c : on_i;
  end

  assign wrap = run_q && (cnt_q == (per_r - 1'b1));
  assign load = !run_q || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      per_r  <= MIN_PER;
      half_r <= CW'(1);
      on_r   <= '0;
      dead_r <= '0;
      lim_r  <= '0;
    end else if (!en) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (load) begin
        cnt_q  <= '0;
        per_r  <= per_c;
        half_r <= half_c;
        on_r   <= on_c;
        dead_r <= dead_i;
        lim_r  <= limit_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign run_o   = run_q;
  assign start_o = run_q && (cnt_q == '0);
  assign cnt_o   = cnt_q;
  assign half_o  = half_r;
  assign on_o    = on_r;
  assign dead_o  = dead_r;
  assign limit_o = lim_r;

  // R2: the counter never leaves the captured period
  a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q < per_r))
    else $error("counter beyond period");

  // R4: working values change only on a period boundary or while idle
  a_r4_capture_boundary: assert property (@(posedge clk) disable iff (rst)
    (run_q && en && !wrap) |=> ($stable(on_r) && $stable(per_r) && $stable(lim_r)))
    else $error("configuration changed mid-period");

endmodule

// File: rtl/pp_window.sv
module pp_window #(
  parameter int SW = 12
) (
  input  logic [SW-1:0] sample_i,
  input  logic [SW-1:0] limit_i,
  output logic          outside_o
);

  // One extra bit so that negating the most negative limit cannot overflow.
  logic signed [SW:0] s_x, l_x, nl_x;

  always_comb begin
    s_x       = $signed({sample_i[SW-1], sample_i});
    l_x       = $signed({limit_i[SW-1], limit_i});
    nl_x      = -l_x;
    outside_o = (s_x > l_x) || (s_x < nl_x);
  end

endmodule

// File: rtl/pp_phase.sv
module pp_phase
  import pp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          allow_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] half_i,
  input  logic [CW-1:0] on_i,
  input  logic [CW-1:0] dead_i,
  output logic          drv_a_o,
  output logic          drv_b_o
);

  seg_e          seg;
  logic [CW:0]   b_end;
  logic          drv_a_q, drv_b_q;

  always_comb begin
    b_end = {1'b0, half_i} + {1'b0, on_i};
    if (cnt_i < on_i)                 seg = SEG_A_ON;
    else if (cnt_i < half_i)          seg = SEG_A_OFF;
    else if ({1'b0, cnt_i} < b_end)   seg = SEG_B_ON;
    else                              seg = SEG_B_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_a_q <= 1'b0;
      drv_b_q <= 1'b0;
    end else begin
      drv_a_q <= allow_i && (seg == SEG_A_ON);
      drv_b_q <= allow_i && (seg == SEG_B_ON);
    end
  end

  assign drv_a_o = drv_a_q;
  assign drv_b_o = drv_b_q;

  // Checker state: consecutive cycles with both drives low, saturating.
  logic [CW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst)                    gap_q <= '1;
    else if (drv_a_q || drv_b_q) gap_q <= '0;
    else if (gap_q != '1)       gap_q <= gap_q + 1'b1;
  end

  // R3: drive B never turns on before the dead interval has elapsed
  a_r3_dead_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_b_q) |-> (gap_q >= dead_i))
    else $error("dead interval violated");

endmodule

// File: rtl/pushpull_limit_drv.sv
module pushpull_limit_drv #(
  parameter int CW = 16,
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] period_cfg,
  input  logic [CW-1:0] on_cfg,
  input  logic [CW-1:0] dead_cfg,
  input  logic [SW-1:0] limit_cfg,
  input  logic [SW-1:0] i_sample,
  output logic          drv_a,
  output logic          drv_b,
  output logic          limit_flag
);

  logic          run_w, start_w, outside_w, go, lim_q, lim_next;
  logic [CW-1:0] cnt_w, half_w, on_w, dead_w;
  logic [SW-1:0] lim_w;

  pp_timebase #(.CW(CW), .SW(SW)) u_tb (
    .clk(clk), .rst(rst), .en(en),
    .period_i(period_cfg), .on_i(on_cfg), .dead_i(dead_cfg), .limit_i(limit_cfg),
    .run_o(run_w), .start_o(start_w), .cnt_o(cnt_w), .half_o(half_w),
    .on_o(on_w), .dead_o(dead_w), .limit_o(lim_w)
  );

  pp_window #(.SW(SW)) u_win (
    .sample_i(i_sample), .limit_i(lim_w), .outside_o(outside_w)
  );

  assign go = en && run_w;

  // Trip at any instant; release only by the test made at a period start.
  always_comb begin
    if (!go)          lim_next = 1'b0;
    else if (start_w) lim_next = outside_w;
    else              lim_next = lim_q || outside_w;
  end

  always_ff @(posedge clk) begin
    if (rst) lim_q <= 1'b0;
    else     lim_q <= lim_next;
  end

  pp_phase #(.CW(CW)) u_ph (
    .clk(clk), .rst(rst), .allow_i(go && !lim_next),
    .cnt_i(cnt_w), .half_i(half_w), .on_i(on_w), .dead_i(dead_w),
    .drv_a_o(drv_a), .drv_b_o(drv_b)
  );

  assign limit_flag = lim_q;

  // R1: never both drives at once
  a_r1_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(drv_a && drv_b))
    else $error("both drives high");

  // R6: an outside sample cuts both drives and raises the flag at the next edge
  a_r6_trip: assert property (@(posedge clk) disable iff (rst)
    (go && outside_w) |=> (limit_flag && !drv_a && !drv_b))
    else $error("trip not applied");

  // R6: inside a period the flag holds once set
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (go && limit_flag && !start_w) |=> limit_flag)
    else $error("flag released mid-period");

  // R7: the flag falls only after a period start or a disable
  a_r7_release_at_start: assert property (@(posedge clk) disable iff (rst)
    $fell(limit_flag) |-> ($past(start_w) || !$past(en)))
    else $error("release off a period boundary");

  // R8: disable quiets everything at the next edge
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!drv_a && !drv_b && !limit_flag))
    else $error("outputs active while disabled");

endmodule

// File: tb/tb_pushpull_limit_drv.sv
module tb_pushpull_limit_drv;

  localparam int CW = 16;
  localparam int SW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [CW-1:0] period_cfg = 16'd20, on_cfg = 16'd6, dead_cfg = 16'd2;
  logic signed [SW-1:0] limit_cfg = 12'sd100;
  logic signed [SW-1:0] i_sample  = 12'sd0;
  logic drv_a, drv_b, limit_flag;

  int tests = 0;
  int fails = 0;
  int overlap = 0;
  bit done = 1'b0;

  pushpull_limit_drv #(.CW(CW), .SW(SW)) dut (
    .clk(clk), .rst(rst), .en(en),
    .period_cfg(period_cfg), .on_cfg(on_cfg), .dead_cfg(dead_cfg),
    .limit_cfg(limit_cfg), .i_sample(i_sample),
    .drv_a(drv_a), .drv_b(drv_b), .limit_flag(limit_flag)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (!rst && drv_a && drv_b) overlap++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sync_a();
    for (int i = 0; i < 200 && !drv_a; i++) tick();
  endtask

  task automatic restart(input int p, input int o, input int d);
    en = 1'b0; tick();
    period_cfg = CW'(p); on_cfg = CW'(o); dead_cfg = CW'(d);
    en = 1'b1; tick();
  endtask

  // Entered on a sample with drv_a high; leaves on the next such sample.
  task automatic measure(output int wa, output int g1, output int wb, output int g2);
    wa = 0; g1 = 0; wb = 0; g2 = 0;
    while (drv_a && wa < 1000)  begin wa++; tick(); end
    while (!drv_b && g1 < 1000) begin g1++; tick(); end
    while (drv_b && wb < 1000)  begin wb++; tick(); end
    while (!drv_a && g2 < 1000) begin g2++; tick(); end
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk(!drv_a && !drv_b && !limit_flag, "R8 reset state", {drv_a, drv_b, limit_flag}, 0);
    rst = 1'b0; tick();
  endtask

  task automatic t_shape(input int p, input int o, input int d,
                         input int ew, input int eg1, input int eg2, input string req);
    int wa, g1, wb, g2;
    restart(p, o, d); sync_a();
    measure(wa, g1, wb, g2);
    chk(wa == ew, {req, " width A"}, wa, ew);
    chk(g1 == eg1, {req, " gap A->B"}, g1, eg1);
    chk(wb == ew, {req, " width B"}, wb, ew);
    chk(g2 == eg2, {req, " gap B->A"}, g2, eg2);
  endtask

  task automatic t_dead_wide();
    int hi = 0;
    restart(20, 5, 12);
    repeat (45) begin if (drv_a || drv_b) hi++; tick(); end
    chk(hi == 0, "R3 dead >= half gives no pulses", hi, 0);
  endtask

  task automatic t_capture();
    int wa, g1, wb, g2;
    restart(20, 6, 2); sync_a();
    on_cfg = 16'd3;
    measure(wa, g1, wb, g2);
    chk(wa == 6 && wb == 6, "R4 running period keeps old width", wa + wb, 12);
    measure(wa, g1, wb, g2);
    chk(wa == 3 && wb == 3, "R4 new width from next period", wa + wb, 6);
    chk(g1 == 7 && g2 == 7, "R4 gaps of new period", g1 + g2, 14);
  endtask

  task automatic t_window_edge();
    int flagged = 0, ahi = 0;
    restart(20, 6, 2); sync_a();
    i_sample = 12'sd100;
    repeat (22) begin if (limit_flag) flagged++; if (drv_a) ahi++; tick(); end
    i_sample = -12'sd100;
    repeat (22) begin if (limit_flag) flagged++; if (drv_a) ahi++; tick(); end
    i_sample = 12'sd0;
    chk(flagged == 0, "R5 sample equal to +/-limit is inside", flagged, 0);
    chk(ahi >= 12, "R5 switching continues at window edge", ahi, 12);
  endtask

  task automatic t_trip();
    int low = 0, bad = 0;
    restart(20, 6, 2); sync_a();
    tick(); tick();
    i_sample = 12'sd101;
    tick();
    chk(!drv_a && limit_flag, "R6 trip cuts drive A at once", {drv_a, limit_flag}, 1);
    i_sample = 12'sd0;
    while (!drv_a && low < 100) begin
      if (drv_b || !limit_flag) bad++;
      low++; tick();
    end
    chk(bad == 0, "R6 off for rest of period", bad, 0);
    chk(low == 17, "R7 restart at next period start", low, 17);
    chk(!limit_flag, "R7 flag clears with restart", limit_flag, 0);
  endtask

  task automatic t_persist();
    int low = 0, bad = 0;
    restart(20, 6, 2); sync_a();
    i_sample = -12'sd101;
    tick();
    chk(!drv_a && limit_flag, "R5 R6 below -limit trips", {drv_a, limit_flag}, 1);
    repeat (24) begin
      if (drv_a || drv_b || !limit_flag) bad++;
      tick();
    end
    chk(bad == 0, "R7 period held dark while outside at start", bad, 0);
    i_sample = 12'sd0;
    tick();
    while (!drv_a && low < 100) begin
      if (drv_b || !limit_flag) bad++;
      low++; tick();
    end
    chk(bad == 0, "R7 no release mid-period", bad, 0);
    chk(low == 14, "R7 resume only at boundary", low, 14);
    chk(!limit_flag, "R7 flag low on resume", limit_flag, 0);
  endtask

  task automatic t_disable();
    int bad = 0;
    restart(20, 6, 2); sync_a();
    i_sample = 12'sd200;
    tick();
    chk(limit_flag, "R6 flag set before disable", limit_flag, 1);
    en = 1'b0; i_sample = 12'sd0;
    tick();
    chk(!drv_a && !drv_b && !limit_flag, "R8 disable clears outputs", {drv_a, drv_b, limit_flag}, 0);
    repeat (3) begin if (drv_a || drv_b || limit_flag) bad++; tick(); end
    chk(bad == 0, "R8 stays quiet while disabled", bad, 0);
    en = 1'b1;
    tick();
    chk(!drv_a, "R8 no pulse on enable edge", drv_a, 0);
    tick();
    chk(drv_a && !drv_b, "R8 drive A rises on following edge", drv_a, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_shape(20, 6, 2, 6, 4, 4, "R1 R2 nominal");
    t_shape(21, 6, 2, 6, 4, 5, "R2 odd period");
    t_shape(20, 9, 3, 7, 3, 3, "R3 clamp");
    t_shape(1, 4, 0, 1, 0, 0, "R2 period floor");
    t_dead_wide();
    t_capture();
    t_window_edge();
    t_trip();
    t_persist();
    t_disable();
    chk(overlap == 0, "R1 never both high", overlap, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule